// File: doc/BRIEF.md
# Eight-Channel Converter Serial Frame Controller

This block is the digital control side of an eight-channel, 12-bit successive-approximation converter with a four-wire serial port. A host frames activity with an active-low chip select and clocks it with a serial clock. The block turns the serial clock edges into 16-cycle conversion slots. Each slot has a short track phase, then a hold instant at which a 12-bit sample is requested from the analog stub for the chosen channel. The result is then shifted out, most significant bit first, behind four zero bits.

A control byte is shifted in on the first eight rising edges of every slot. Only a 3-bit channel field inside that byte matters, and it selects the channel for the following slot. The block also reports when the converter may be powered down. It does this while chip select is high, and in the gap that runs from the sixteenth falling edge of a slot to the first falling edge of the next.

The serial pins are sampled by the system clock `clk`. Every high or low phase of the serial clock, and every chip-select level, must last at least three system clock cycles.

Top module: `adcfc_top`

## Requirements
- R1: While `cs_n` is high, no serial clock edge is counted: `pwr_dn` is 1, `trk` is 0, `smp_req` is 0 and `dout` is 0.
- R2: `trk` is 1 from falling edge 1 of a slot up to falling edge 4, and 0 otherwise.
- R3: Falling edge 4 of a slot is the hold instant. `smp_req` pulses for exactly one `clk` cycle and `smp_ch` carries the slot's channel code, and the 12-bit `smp_data` present during that pulse becomes the slot's result.
- R4: After falling edge k of a slot (k = 1..16), `dout` is 0 for k = 1..4 and result bit 16-k for k = 5..16, so the most significant bit goes first.
- R5: `dout_oe` is 1 exactly while `cs_n` is low.
- R6: `din` is sampled on rising edges 1..8 of a slot, control bit 7 first. Control bits 5:3 (rising edges 3, 4, 5) form the channel code, and bits 7, 6, 2, 1 and 0 have no effect on any output.
- R7: A channel code written in one slot selects the channel of the next slot. Channel code c selects input c+1, and after reset the code is 0.
- R8: While `cs_n` stays low, slots follow one another. Rising edge 16 closes a slot, and the next falling edge is falling edge 1 of a new slot.
- R9: While `cs_n` is low, `pwr_dn` is 1 only between falling edge 16 of a slot and falling edge 1 of the next.
- R10: If the serial clock is low when `cs_n` falls, the fall of `cs_n` itself is falling edge 1. If the serial clock is high, the first later falling edge is falling edge 1, and until then the block is powered with `trk` at 0.
- R11: A rise of `cs_n` in mid-slot abandons the slot. A channel code takes effect only if all eight control edges of its slot were seen; otherwise the previous code stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select that frames the slots |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial control data |
| smp_data | input | 12 | Sample for `smp_ch`, supplied by the analog stub |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` |
| smp_req | output | 1 | One-cycle hold request |
| smp_ch | output | 3 | Channel code of the current slot |
| trk | output | 1 | Track phase indication |
| pwr_dn | output | 1 | Power-down indication |

## Verification
A change on `cs_n` or `sclk` becomes an internal edge at the next `clk` rising edge. At that same edge `dout`, `trk` and `pwr_dn` take their new values, and `smp_req` for the hold instant is high for only the cycle that follows that edge. The bench drives every pin change on a falling `clk` edge. It reads `smp_req` and `smp_ch` at the very next falling edge, and reads the other outputs four cycles after the change, just before the next serial transition. The bench recomputes each expected bit from the channel it tracks and from its own sample function.

// File: rtl/adcfc_pkg.sv
// Shared constants and types for the serial frame controller.
package adcfc_pkg;
    parameter int RES_W     = 12;   // result width
    parameter int CH_W      = 3;    // channel code width
    parameter int SLOT_LEN  = 16;   // serial clocks per conversion slot
    parameter int TRACK_LEN = 3;    // serial clocks of track phase
    parameter int CTRL_LEN  = 8;    // control bits per slot
    parameter int ADDR_LSB  = 3;    // lowest control bit of channel field

    // Phase of the current slot as seen from outside.
    typedef enum logic [2:0] {
        PH_OFF,     // chip select high
        PH_WAIT,    // selected, no falling edge yet
        PH_TRACK,   // acquiring
        PH_CONV,    // converting and shifting
        PH_REST     // between falling edge SLOT_LEN and the next slot
    } phase_e;
endpackage

// File: rtl/adcfc_edge.sv
// Rebuilds the gated internal serial clock and detects its edges.
// Assumes each sclk / cs_n level lasts at least two clk cycles.
// The internal clock is forced high while cs_n is high, so a cs_n fall
// with sclk low yields a falling edge, and a cs_n rise is never counted.
module adcfc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic fall_ev,
    output logic rise_ev
);
    logic iclk_d;
    logic iclk_q;

    assign iclk_d = sclk | cs_n;

    // Remember the previous internal clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) iclk_q <= 1'b1;
        else        iclk_q <= iclk_d;
    end

    // Edge strobes, valid for one clk cycle; rising ones only inside a frame.
    always_comb begin
        fall_ev = iclk_q & ~iclk_d;
        rise_ev = ~iclk_q & iclk_d & ~cs_n;
    end
endmodule

// File: rtl/adcfc_seq.sv
// Slot sequencer: counts falling and rising serial edges within a slot,
// derives the phase and issues the hold strobe.
// Assumes strobes from adcfc_edge; counters clear while cs_n is high.
module adcfc_seq #(
    parameter int SLOT_LEN  = 16,
    parameter int TRACK_LEN = 3,
    parameter int CNT_W     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               fall_ev,
    input  logic               rise_ev,
    output logic [CNT_W-1:0]   fnext,
    output logic [CNT_W-1:0]   rnext,
    output adcfc_pkg::phase_e  phase,
    output logic               conv_start,
    output logic               hold_pulse
);
    import adcfc_pkg::*;

    localparam logic [CNT_W-1:0] LAST  = CNT_W'(SLOT_LEN);
    localparam logic [CNT_W-1:0] TRK_E = CNT_W'(TRACK_LEN);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] fcnt_q;
    logic [CNT_W-1:0] rcnt_q;

    // Next edge indices, wrapping after the last edge of a slot.
    always_comb begin
        fnext = (fcnt_q == LAST) ? ONE : fcnt_q + ONE;
        rnext = (rcnt_q == LAST) ? ONE : rcnt_q + ONE;
    end

    // A falling edge opens a new slot when nothing or a full slot precedes it.
    assign conv_start = fall_ev && ((fcnt_q == '0) || (fcnt_q == LAST));

    // Falling edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) fcnt_q <= '0;
        else if (fall_ev)   fcnt_q <= fnext;
    end

    // Rising edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) rcnt_q <= '0;
        else if (rise_ev)   rcnt_q <= rnext;
    end

    // Hold strobe on the falling edge that ends tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) hold_pulse <= 1'b0;
        else                hold_pulse <= fall_ev && (fcnt_q == TRK_E);
    end

    // Phase decode from the edge count.
    always_comb begin
        if (cs_n)                 phase = PH_OFF;
        else if (fcnt_q == '0)    phase = PH_WAIT;
        else if (fcnt_q <= TRK_E) phase = PH_TRACK;
        else if (fcnt_q == LAST)  phase = PH_REST;
        else                      phase = PH_CONV;
    end
endmodule

// File: rtl/adcfc_ctrl.sv
// Control input: keeps only the channel field of each control byte and
// commits it once all control edges of the slot are seen.
// Assumes rnext from adcfc_seq; the committed code survives chip select.
module adcfc_ctrl #(
    parameter int CTRL_LEN = 8,
    parameter int ADDR_LSB = 3,
    parameter int CH_W     = 3,
    parameter int CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_ev,
    input  logic [CNT_W-1:0] rnext,
    input  logic             din,
    input  logic             conv_start,
    output logic [CH_W-1:0]  cur_ch
);
    // Rising edge indices of the first and last channel field bit.
    localparam logic [CNT_W-1:0] FLD_FIRST = CNT_W'(CTRL_LEN - ADDR_LSB - CH_W + 1);
    localparam logic [CNT_W-1:0] FLD_LAST  = CNT_W'(CTRL_LEN - ADDR_LSB);
    localparam logic [CNT_W-1:0] COMMIT    = CNT_W'(CTRL_LEN);

    logic [CH_W-1:0] fld_sh;
    logic [CH_W-1:0] next_ch;
    logic            in_field;

    assign in_field = (rnext >= FLD_FIRST) && (rnext <= FLD_LAST);

    // Shift in the channel field bits; other control bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)                   fld_sh <= '0;
        else if (rise_ev && in_field) fld_sh <= (fld_sh << 1) | CH_W'(din);
    end

    // Commit the code after the last control edge of the slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                          next_ch <= '0;
        else if (rise_ev && rnext == COMMIT) next_ch <= fld_sh;
    end

    // Latch the channel of the slot that is starting.
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_ch <= '0;
        else if (conv_start) cur_ch <= next_ch;
    end
endmodule

// File: rtl/adcfc_out.sv
// Result path: captures the sample at the hold strobe and shifts it out
// behind the leading zeros, one bit per falling serial edge.
// Assumes the hold strobe precedes the first data edge by several clks.
module adcfc_out #(
    parameter int RES_W    = 12,
    parameter int SLOT_LEN = 16,
    parameter int CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             fall_ev,
    input  logic [CNT_W-1:0] fnext,
    input  logic             hold_pulse,
    input  logic [RES_W-1:0] smp_data,
    output logic             dout
);
    localparam logic [CNT_W-1:0] LEAD = CNT_W'(SLOT_LEN - RES_W);

    logic [RES_W-1:0] res_sh;
    logic             data_edge;

    assign data_edge = fall_ev && (fnext > LEAD);

    // Load the sample at hold, then move one bit up per data edge.
    always_ff @(posedge clk) begin
        if (!rst_n)          res_sh <= '0;
        else if (hold_pulse) res_sh <= smp_data;
        else if (data_edge)  res_sh <= res_sh << 1;
    end

    // Output bit: zero outside a frame and in the leading positions.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) dout <= 1'b0;
        else if (data_edge) dout <= res_sh[RES_W-1];
        else if (fall_ev)   dout <= 1'b0;
    end
endmodule

// File: rtl/adcfc_top.sv
// Serial frame controller for an eight-channel 12-bit converter.
// Assumes serial pins stable for at least three clk cycles per level.
module adcfc_top #(
    parameter int RES_W     = adcfc_pkg::RES_W,
    parameter int CH_W      = adcfc_pkg::CH_W,
    parameter int SLOT_LEN  = adcfc_pkg::SLOT_LEN,
    parameter int TRACK_LEN = adcfc_pkg::TRACK_LEN,
    parameter int CTRL_LEN  = adcfc_pkg::CTRL_LEN,
    parameter int ADDR_LSB  = adcfc_pkg::ADDR_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] smp_data,
    output logic             dout,
    output logic             dout_oe,
    output logic             smp_req,
    output logic [CH_W-1:0]  smp_ch,
    output logic             trk,
    output logic             pwr_dn
);
    import adcfc_pkg::*;

    localparam int CNT_W = $clog2(SLOT_LEN + 1);

    logic             fall_ev;
    logic             rise_ev;
    logic [CNT_W-1:0] fnext;
    logic [CNT_W-1:0] rnext;
    phase_e           phase;
    logic             conv_start;
    logic             hold_pulse;

    adcfc_edge u_edge (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .fall_ev(fall_ev), .rise_ev(rise_ev)
    );

    adcfc_seq #(.SLOT_LEN(SLOT_LEN), .TRACK_LEN(TRACK_LEN), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fall_ev(fall_ev), .rise_ev(rise_ev),
        .fnext(fnext), .rnext(rnext), .phase(phase),
        .conv_start(conv_start), .hold_pulse(hold_pulse)
    );

    adcfc_ctrl #(.CTRL_LEN(CTRL_LEN), .ADDR_LSB(ADDR_LSB), .CH_W(CH_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .rnext(rnext), .din(din),
        .conv_start(conv_start), .cur_ch(smp_ch)
    );

    adcfc_out #(.RES_W(RES_W), .SLOT_LEN(SLOT_LEN), .CNT_W(CNT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fall_ev(fall_ev), .fnext(fnext),
        .hold_pulse(hold_pulse), .smp_data(smp_data), .dout(dout)
    );

    // Port level indications.
    assign dout_oe = ~cs_n;
    assign smp_req = hold_pulse;
    assign trk     = (phase == PH_TRACK);
    assign pwr_dn  = (phase == PH_OFF) || (phase == PH_REST);
endmodule

// File: rtl/adcfc_checker.sv
// Port-level temporal checks for adcfc_top, attached by bind.
module adcfc_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic dout,
    input logic dout_oe,
    input logic smp_req,
    input logic trk,
    input logic pwr_dn
);
    // R1: a deselected block stays quiet and powered down.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> (pwr_dn && !trk && !smp_req));

    // R3: the hold request lasts one cycle.
    a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |=> !smp_req);

    // R3: the hold request comes exactly as tracking ends, while powered.
    a_r3_hold_ends_track: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |-> (!trk && $past(trk) && !pwr_dn));

    // R4: a slot starts with a zero on the data line.
    a_r4_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trk) |-> !dout);

    // R5: while the output stays disabled the data line is low.
    a_r5_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!dout_oe && $past(!dout_oe)) |-> !dout);

    // R9: tracking and power-down never overlap.
    a_r9_pd_not_track: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_dn && trk));
endmodule

bind adcfc_top adcfc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout(dout), .dout_oe(dout_oe),
    .smp_req(smp_req), .trk(trk), .pwr_dn(pwr_dn)
);

// File: tb/adcfc_top_bench.sv
// Bench for adcfc_top: sweeps channel codes and ignored control bits over
// back-to-back slots, both chip-select entry cases and aborted slots.
module adcfc_top_bench;
    localparam int H = 4;   // clk cycles per serial clock phase

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        din = 1'b0;
    logic [11:0] smp_data;
    logic        dout, dout_oe, smp_req, trk, pwr_dn;
    logic [2:0]  smp_ch;

    int n_chk = 0;
    int n_err = 0;
    int salt = 0;
    int bench_next = 0;   // channel code pending for the next slot
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Sample stub: value depends on channel and a per-slot salt.
    function automatic logic [11:0] sample_of(input int ch, input int s);
        if (s % 5 == 0)      return 12'h000;
        else if (s % 5 == 1) return 12'hFFF;
        else                 return 12'((s * 733 + ch * 97 + 41) % 4096);
    endfunction

    assign smp_data = sample_of(int'(smp_ch), salt);

    adcfc_top u_adcfc_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .smp_data(smp_data), .dout(dout), .dout_oe(dout_oe), .smp_req(smp_req),
        .smp_ch(smp_ch), .trk(trk), .pwr_dn(pwr_dn)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R1/R5: checks that hold while deselected.
    task automatic check_idle(input string req);
        chk(dout_oe == 1'b0, {req, " R5 oe"}, int'(dout_oe), 0);
        chk(pwr_dn == 1'b1, {req, " R1 pwr_dn"}, int'(pwr_dn), 1);
        chk(trk == 1'b0, {req, " R1 trk"}, int'(trk), 0);
        chk(dout == 1'b0, {req, " R1 dout"}, int'(dout), 0);
        chk(smp_req == 1'b0, {req, " R1 smp_req"}, int'(smp_req), 0);
    endtask

    // Open a frame while sclk is high (R10); with sclk low the slot task drops cs_n.
    task automatic open_frame();
        if (sclk) begin
            cs_n = 1'b0;
            repeat (H) @(negedge clk);
            chk(pwr_dn == 1'b0, "R10 powered before first edge", int'(pwr_dn), 0);
            chk(trk == 1'b0, "R10 no track before first edge", int'(trk), 0);
            chk(dout_oe == 1'b1, "R5 oe in frame", int'(dout_oe), 1);
        end
    endtask

    task automatic close_frame();
        cs_n = 1'b1;
        repeat (H) @(negedge clk);
        check_idle("close");
    endtask

    // Run ncyc serial cycles of one slot with control byte ctrl.
    task automatic run_slot(input logic [7:0] ctrl, input int ncyc);
        int          conv_ch;
        logic [11:0] val;
        logic        exp_bit;
        salt++;
        conv_ch = bench_next;
        val = sample_of(conv_ch, salt);
        for (int k = 1; k <= ncyc; k++) begin
            if (k == 1 && cs_n) cs_n = 1'b0;   // R10: cs_n fall is falling edge 1
            else                sclk = 1'b0;
            @(negedge clk);
            chk(smp_req == (k == 4), "R3 hold strobe timing", int'(smp_req), int'(k == 4));
            if (k == 4)
                chk(int'(smp_ch) == conv_ch, "R7 channel of slot", int'(smp_ch), conv_ch);
            repeat (H - 1) @(negedge clk);
            exp_bit = (k <= 4) ? 1'b0 : val[16 - k];
            chk(dout == exp_bit, "R4 serial bit", int'(dout), int'(exp_bit));
            chk(trk == (k <= 3), "R2 track phase", int'(trk), int'(k <= 3));
            chk(pwr_dn == (k == 16), "R9 power-down gap", int'(pwr_dn), int'(k == 16));
            chk(dout_oe == 1'b1, "R5 oe", int'(dout_oe), 1);
            sclk = 1'b1;
            din = (k <= 8) ? ctrl[8 - k] : 1'(k * 7 % 3);   // R6 bit 7 first
            repeat (H) @(negedge clk);
            if (k == 8) bench_next = int'(ctrl[5:3]);        // R6/R11 committed
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 reset");

        // Frame with sclk high at select; first slot uses code 0 (R7).
        open_frame();
        run_slot({2'b11, 3'd5, 3'b101}, 16);
        // R6/R8: back-to-back sweep of every code with varied ignored bits.
        for (int j = 0; j < 4; j++) begin
            for (int c = 0; c < 8; c++) begin
                logic [2:0] junk;
                junk = 3'(j * 3 + c);
                run_slot({junk[1:0], 3'(c), junk}, 16);
            end
        end
        close_frame();

        // R1: sclk activity while deselected has no effect.
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        check_idle("R1 sclk low deselected");

        // R10: cs_n falls while sclk low.
        open_frame();
        run_slot(8'b0001_0110, 16);   // code 2
        sclk = 1'b0;                  // R8: falling edge 1 of next slot
        repeat (H) @(negedge clk);
        chk(trk == 1'b1, "R8 next slot tracks", int'(trk), 1);
        chk(pwr_dn == 1'b0, "R9 powered in new slot", int'(pwr_dn), 0);
        close_frame();                // cs_n rises with sclk low: not counted

        // R11: abort before the eighth control edge keeps the old code.
        open_frame();
        run_slot(8'b0011_1000, 6);    // code 7 not committed
        close_frame();
        open_frame();
        run_slot(8'b0010_0000, 16);   // R11: still code 2; writes 4
        close_frame();
        // R11: abort after the eighth control edge keeps the new code.
        open_frame();
        run_slot(8'b1111_0111, 9);    // code 6 committed
        close_frame();
        open_frame();
        run_slot(8'b0000_0000, 16);   // R11: channel code 6
        run_slot(8'b0000_1000, 16);   // R7: code 0 from previous slot
        close_frame();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule